// File: doc/BRIEF.md
# ATA Device Software Reset Sequencer

This block resets an ATA device through the device control register, with no reset wire involved. A one-cycle start pulse begins a fixed sequence. The block writes a control byte with the soft-reset bit set and keeps that bit high for a guaranteed minimum time. It then writes a second byte that clears the bit. After that it polls the device busy flag until the flag drops. The interrupt-disable bit stays set in every byte written during the sequence.

The release write does not wait for busy to fall. This is what a serial link needs, because the second control frame must go out while the device still reports busy. The hold time is given in nanoseconds and converted to clock cycles from the clock frequency parameter.

On success the block raises two sticky requests for the host logic: a reconfigure request and an identify request. Any reset erases the transfer mode, the multiple-block count and similar settings, and the device must be identified again before normal traffic resumes. In parallel-bus mode the reset hits both devices on the cable, so both reconfigure slots are flagged. In serial mode only slot 0 is flagged. If busy stays set for longer than the timeout, the sequence ends with an error and raises no requests. The commands that restore the settings are handled elsewhere.

Top module: `ata_srst_seq`

## Requirements
- R1: After reset, ctl_byte is 8'h00, and ctl_wr, done, timeout_err, reconf_req and ident_req are all 0.
- R2: A start pulse while idle produces a control write on the next cycle with ctl_byte = 8'h06, which is soft-reset bit 2 set and interrupt-disable bit 1 set.
- R3: The release write (ctl_byte = 8'h02) follows the assert write by exactly HOLD_CYC+1 cycles, where HOLD_CYC = ceil(CLK_MHZ*HOLD_NS/1000). Bit 2 stays 1 in every cycle between the two writes.
- R4: The release write is issued while bsy is still 1. Every control write has bit 1 set.
- R5: If bsy is 0 when sampled D cycles after the release write, with 1 <= D <= TMO_CYC, done pulses for one cycle D+1 cycles after the release write.
- R6: If bsy remains 1 for TMO_CYC sampled cycles after the release write, timeout_err pulses for one cycle TMO_CYC+1 cycles after the release write, and reconf_req and ident_req stay 0.
- R7: One cycle after done, ident_req is 1. reconf_req is 2'b11 if the mode latched at start was parallel (sata_mode=0), and 2'b01 if it was serial (sata_mode=1). A change of sata_mode after start has no effect.
- R8: reconf_req and ident_req hold their values until the next accepted start, which clears them.
- R9: A start pulse while a sequence is running is ignored. The release timing is unchanged, and no further write follows the end of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a software reset |
| bsy | input | 1 | Current device busy status sample |
| sata_mode | input | 1 | 1 = serial link, 0 = parallel bus with two devices |
| ctl_byte | output | 8 | Device control register value |
| ctl_wr | output | 1 | Write strobe for ctl_byte |
| done | output | 1 | One-cycle pulse: reset finished, busy cleared |
| timeout_err | output | 1 | One-cycle pulse: busy did not clear in time |
| reconf_req | output | 2 | Per-device-slot request to restore settings |
| ident_req | output | 1 | Request to identify the device again |

## Verification
The bench measures the exact spacing between the assert write and the release write, with busy held high. A hold counter that is off by one, or that waits for busy, shows up as a wrong cycle count or as a release that never arrives.

The bench drops busy at the last allowed poll and, in a separate case, one cycle later. A design with the timeout compare off by one would report success where a timeout is due, or the reverse.

Other cases check the following:
- Sticky requests are cleared by a later timed-out run. A design that never clears them would leave stale requests.
- A start pulse in mid-sequence must not restart the hold or trigger an extra write.
- Toggling the mode input mid-sequence must not change which slots get the reconfigure flag.

// File: rtl/ata_srst_seq.sv
module ata_srst_seq #(
  parameter int CLK_MHZ = 250,
  parameter int HOLD_NS = 5000,
  parameter int TMO_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bsy,
  input  logic       sata_mode,
  output logic [7:0] ctl_byte,
  output logic       ctl_wr,
  output logic       done,
  output logic       timeout_err,
  output logic [1:0] reconf_req,
  output logic       ident_req
);
  localparam int HOLD_CYC = (CLK_MHZ * HOLD_NS + 999) / 1000;
  localparam int MAXC     = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
  localparam int CW       = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);
  localparam logic [7:0] B_ASSERT  = 8'h06;
  localparam logic [7:0] B_RELEASE = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_ASSERT, S_HOLD, S_RELEASE, S_WAIT, S_DONE, S_TMO
  } st_t;

  st_t           state, state_n;
  logic [CW-1:0] cnt;
  logic          sata_q;

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:    if (start) state_n = S_ASSERT;
      S_ASSERT:  state_n = S_HOLD;
      S_HOLD:    if (cnt == HOLD_LAST) state_n = S_RELEASE;
      S_RELEASE: state_n = S_WAIT;
      S_WAIT:    if (!bsy) state_n = S_DONE;
                 else if (cnt == TMO_LAST) state_n = S_TMO;
      S_DONE:    state_n = S_IDLE;
      S_TMO:     state_n = S_IDLE;
      default:   state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sata_q     <= 1'b0;
      reconf_req <= 2'b00;
      ident_req  <= 1'b0;
    end else begin
      state <= state_n;
      if ((state == S_HOLD || state == S_WAIT) && state_n == state)
        cnt <= cnt + 1'b1;
      else
        cnt <= '0;
      if (state == S_IDLE && start) begin
        sata_q     <= sata_mode;
        reconf_req <= 2'b00;
        ident_req  <= 1'b0;
      end else if (state == S_DONE) begin
        reconf_req <= sata_q ? 2'b01 : 2'b11;
        ident_req  <= 1'b1;
      end
    end
  end

  assign ctl_wr      = (state == S_ASSERT) || (state == S_RELEASE);
  assign ctl_byte    = (state == S_ASSERT || state == S_HOLD) ? B_ASSERT :
                       (state == S_RELEASE || state == S_WAIT) ? B_RELEASE : 8'h00;
  assign done        = (state == S_DONE);
  assign timeout_err = (state == S_TMO);

  int unsigned srst_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_run <= 0;
    else if (ctl_byte[2]) srst_run <= srst_run + 1;
    else srst_run <= 0;
  end

  // R3
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_byte[2]) |-> (srst_run >= HOLD_CYC + 1));

  // R3
  srst_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_byte[2]) |=> ctl_byte[2]);

  // R4
  nien_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> ctl_byte[1]);

  // R6
  tmo_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (reconf_req == 2'b00 && !ident_req));

  // R7
  ident_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ident_req) |-> $past(done));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_ata_srst_seq.sv
module tb_ata_srst_seq;
  localparam int CLK_MHZ = 4;
  localparam int HOLD_NS = 5000;
  localparam int TMO_CYC = 30;
  localparam int EXP_HOLD = (CLK_MHZ * HOLD_NS + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bsy = 1'b0, sata_mode = 1'b0;
  logic [7:0] ctl_byte;
  logic ctl_wr, done, timeout_err, ident_req;
  logic [1:0] reconf_req;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ata_srst_seq #(.CLK_MHZ(CLK_MHZ), .HOLD_NS(HOLD_NS), .TMO_CYC(TMO_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bsy(bsy), .sata_mode(sata_mode),
    .ctl_byte(ctl_byte), .ctl_wr(ctl_wr), .done(done), .timeout_err(timeout_err),
    .reconf_req(reconf_req), .ident_req(ident_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(ctl_byte == 8'h00, "R1 ctl_byte", ctl_byte, 0);
    chk({ctl_wr, done, timeout_err, ident_req, reconf_req} == 6'b0, "R1 outputs",
        {ctl_wr, done, timeout_err, ident_req, reconf_req}, 0);
  endtask

  task automatic run_seq(input bit sata, input int d, input bit flip, input bit poke,
                         input string name);
    int n;
    int k;
    bit srst_ok;
    bit ok_exp;
    int exp_k;
    bit got_done;
    bit got_tmo;
    @(negedge clk);
    sata_mode = sata; bsy = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ctl_wr == 1'b1 && ctl_byte == 8'h06, {"R2 assert write ", name}, ctl_byte, 6);
    n = 0; srst_ok = 1'b1;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (ctl_wr) break;
      if (!ctl_byte[2]) srst_ok = 1'b0;
      if (flip && n == 3) sata_mode = ~sata;
      if (poke && n == 5) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(n == EXP_HOLD + 1, {"R3 hold spacing ", name}, n, EXP_HOLD + 1);
    chk(srst_ok, {"R3 srst held ", name}, srst_ok, 1);
    chk(ctl_byte == 8'h02 && bsy == 1'b1, {"R4 release under busy ", name}, ctl_byte, 2);
    ok_exp = (d <= TMO_CYC);
    exp_k = ok_exp ? d + 1 : TMO_CYC + 1;
    k = 0; got_done = 1'b0; got_tmo = 1'b0;
    while (k < TMO_CYC + 10) begin
      @(negedge clk);
      k++;
      if (done) begin got_done = 1'b1; break; end
      if (timeout_err) begin got_tmo = 1'b1; break; end
      if (k == d) bsy = 1'b0;
    end
    if (ok_exp) begin
      chk(got_done && k == exp_k, {"R5 done timing ", name}, k, exp_k);
    end else begin
      chk(got_tmo && k == exp_k, {"R6 timeout timing ", name}, k, exp_k);
      chk(reconf_req == 2'b00 && !ident_req, {"R6 no request ", name}, reconf_req, 0);
    end
    bsy = 1'b0;
    @(negedge clk);
    chk(!done && !timeout_err, {"R5 single pulse ", name}, {done, timeout_err}, 0);
    if (ok_exp) begin
      chk(ident_req == 1'b1, {"R7 ident ", name}, ident_req, 1);
      chk(reconf_req == (sata ? 2'b01 : 2'b11), {"R7 reconf slots ", name},
          reconf_req, sata ? 1 : 3);
    end else begin
      chk(reconf_req == 2'b00 && !ident_req, {"R8 cleared by new start ", name},
          reconf_req, 0);
    end
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      chk(!ctl_wr && ctl_byte == 8'h00, {"R9 quiet after end ", name}, ctl_wr, 0);
    end
    if (ok_exp)
      chk(ident_req == 1'b1, {"R8 requests held ", name}, ident_req, 1);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_seq(1'b0, 3, 1'b0, 1'b0, "pata");
    run_seq(1'b1, 1, 1'b0, 1'b0, "sata");
    run_seq(1'b0, TMO_CYC, 1'b0, 1'b0, "last poll");
    run_seq(1'b1, TMO_CYC + 1, 1'b0, 1'b0, "timeout");
    run_seq(1'b0, 5, 1'b0, 1'b1, "start ignored R9");
    run_seq(1'b1, 4, 1'b1, 1'b0, "mode flip R7");
    run_seq(1'b0, 2, 1'b1, 1'b0, "mode flip pata");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule